// File: doc/BRIEF.md
# Linked-List Segment DMA Channel

This block is one DMA channel that takes its work from a chain of segment descriptors held in memory, not from registers that software rewrites for each transfer. Software supplies the address of the first descriptor and pulses a start input. The channel then reads that descriptor over a word-wide memory port, loads its working registers from it and copies the segment one 32-bit word at a time. It then follows the link to the next descriptor. The chain stops after the descriptor whose link word carries the end-of-chain flag.

Each descriptor takes a 32-byte-aligned slot and four words are read from it. The word at byte offset 0 gives the source address and offset 4 gives the destination address. Offset 8 gives the link word and offset 12 gives the byte count. The link word's bit 0 marks the last descriptor. The memory port has a valid/ready request channel and a separate read-data valid, and it carries only one access at a time. A status output reports that the chain has finished.

Top module: `desc_dma`

## Requirements
- R1: After reset, busy and done are 0 and no memory request is raised. While the channel is idle it raises no request.
- R2: A start pulse while idle takes the descriptor address with its low five bits forced to zero. Every descriptor address the channel uses keeps bits 4:0 at zero, and bytes 16 to 31 of a descriptor slot are never read.
- R3: A descriptor is read as four word reads at slot offsets 0, 4, 8 and 12, in that order. They load, in turn, the source address, the destination address, the link word and the byte count.
- R4: Each data word is moved by a read at the source address followed by a write of the returned data to the destination address. Both addresses then advance by 4 and the count drops by 4. The segment ends when the count reaches zero, and the low two bits of the byte count are ignored.
- R5: A descriptor whose count is zero after masking completes at once, with no data read or write.
- R6: Bit 0 of the link word is the end-of-chain flag. The next descriptor address is the link word with bits 4:0 cleared, so bits 4:1 have no effect.
- R7: When a descriptor without the flag completes, the channel fetches the linked descriptor. When a flagged descriptor completes, done becomes 1 and busy becomes 0. Done stays 1 until the next accepted start, which clears it.
- R8: A start pulse while busy is ignored.
- R9: A request stays raised with unchanged address, direction and write data until it is accepted. After a read is accepted, no new request is raised until its data returns. A write completes at its handshake.

Top module port order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| start_addr | input | 32 | First descriptor address (low five bits ignored) |
| busy | output | 1 | Chain in progress |
| done | output | 1 | Sticky chain-complete status |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_we | output | 1 | 1 = write, 0 = read |
| req_addr | output | 32 | Request byte address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_rdata | input | 32 | Read data |

## Verification
The bench covers several corner cases:
- A count of zero in the middle of a chain. A design that still started a data access would write over the guard word at that descriptor's destination.
- Count values of 3 and 38. A design that kept the low count bits would hang, or would copy a partial word past the guard.
- A link word with bits 4:1 set and a start address that is not aligned. A design that did not mask these would fetch from the wrong slot, and the logged fetch addresses would be wrong.
- A second start pulse issued mid-chain. A design that reloaded the address on that pulse would touch the second chain's destination.
- Random back-pressure on the ready signal. A design that changed a pending request would show up as a held-request mismatch.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;

    // Word and descriptor geometry
    localparam int unsigned DW         = 32;
    localparam int unsigned WORD_BYTES = DW / 8;
    localparam int unsigned WORD_SH    = $clog2(WORD_BYTES);
    localparam int unsigned SLOT_BITS  = 5;

    // Descriptor word indices inside a slot
    localparam logic [1:0] FLD_SRC  = 2'd0;
    localparam logic [1:0] FLD_DST  = 2'd1;
    localparam logic [1:0] FLD_LINK = 2'd2;
    localparam logic [1:0] FLD_CNT  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FWAIT,
        ST_RD,
        ST_RWAIT,
        ST_WR
    } st_e;

    typedef struct packed {
        st_e           st;
        logic [1:0]    fld;
        logic [DW-1:0] cur;
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [DW-1:0] nxt;
        logic [DW-1:0] cnt;
        logic [DW-1:0] data;
        logic          last;
        logic          done;
    } regs_t;

endpackage

// File: rtl/desc_dma_link.sv
module desc_dma_link #(
    parameter int unsigned W  = 32,
    parameter int unsigned AB = 5
) (
    input  logic [W-1:0] word,
    output logic [W-1:0] next_addr,
    output logic         last
);
    localparam logic [W-1:0] HI_MASK = ~((W'(1) << AB) - W'(1));

    assign next_addr = word & HI_MASK;
    assign last      = word[0];
endmodule

// File: rtl/desc_dma_req.sv
module desc_dma_req
    import desc_dma_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned SH = 2
) (
    input  st_e          st,
    input  logic [1:0]   fld,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    input  logic [W-1:0] data,
    output logic         valid,
    output logic         we,
    output logic [W-1:0] addr,
    output logic [W-1:0] wdata
);
    logic [W-1:0] fld_off;

    assign fld_off = {{(W-2){1'b0}}, fld} << SH;

    always_comb begin
        valid = 1'b0;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        case (st)
            ST_FETCH: begin
                valid = 1'b1;
                addr  = cur + fld_off;
            end
            ST_RD: begin
                valid = 1'b1;
                addr  = src;
            end
            ST_WR: begin
                valid = 1'b1;
                we    = 1'b1;
                addr  = dst;
                wdata = data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/desc_dma.sv
module desc_dma
    import desc_dma_pkg::*;
#(
    parameter int unsigned ALIGN_BITS = SLOT_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] start_addr,
    output logic          busy,
    output logic          done,
    output logic          req_valid,
    input  logic          req_ready,
    output logic          req_we,
    output logic [DW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_rdata
);
    localparam logic [DW-1:0] SLOT_MASK = ~((DW'(1) << ALIGN_BITS) - DW'(1));
    localparam logic [DW-1:0] CNT_MASK  = ~(DW'(WORD_BYTES) - DW'(1));
    localparam logic [DW-1:0] STEP      = DW'(WORD_BYTES);

    regs_t         r_q, r_d;
    logic [DW-1:0] link_addr;
    logic          link_last;
    logic [DW-1:0] cnt_in;
    logic          finish;
    logic [DW-1:0] cur_desc_w;

    desc_dma_link #(.W(DW), .AB(ALIGN_BITS)) u_link (
        .word      (rsp_rdata),
        .next_addr (link_addr),
        .last      (link_last)
    );

    desc_dma_req #(.W(DW), .SH(WORD_SH)) u_req (
        .st    (r_q.st),
        .fld   (r_q.fld),
        .cur   (r_q.cur),
        .src   (r_q.src),
        .dst   (r_q.dst),
        .data  (r_q.data),
        .valid (req_valid),
        .we    (req_we),
        .addr  (req_addr),
        .wdata (req_wdata)
    );

    assign cnt_in = rsp_rdata & CNT_MASK;

    always_comb begin
        r_d    = r_q;
        finish = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.cur  = start_addr & SLOT_MASK;
                    r_d.fld  = FLD_SRC;
                    r_d.done = 1'b0;
                    r_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (req_ready) r_d.st = ST_FWAIT;
            end
            ST_FWAIT: begin
                if (rsp_valid) begin
                    case (r_q.fld)
                        FLD_SRC:  r_d.src = rsp_rdata;
                        FLD_DST:  r_d.dst = rsp_rdata;
                        FLD_LINK: begin
                            r_d.nxt  = link_addr;
                            r_d.last = link_last;
                        end
                        default:  r_d.cnt = cnt_in;
                    endcase
                    if (r_q.fld == FLD_CNT) begin
                        if (cnt_in == '0) finish = 1'b1;
                        else              r_d.st = ST_RD;
                    end else begin
                        r_d.fld = r_q.fld + 2'd1;
                        r_d.st  = ST_FETCH;
                    end
                end
            end
            ST_RD: begin
                if (req_ready) r_d.st = ST_RWAIT;
            end
            ST_RWAIT: begin
                if (rsp_valid) begin
                    r_d.data = rsp_rdata;
                    r_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (req_ready) begin
                    r_d.src = r_q.src + STEP;
                    r_d.dst = r_q.dst + STEP;
                    r_d.cnt = r_q.cnt - STEP;
                    if (r_q.cnt == STEP) finish = 1'b1;
                    else                 r_d.st = ST_RD;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (finish) begin
            if (r_q.last) begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end else begin
                r_d.cur = r_q.nxt;
                r_d.fld = FLD_SRC;
                r_d.st  = ST_FETCH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, fld: 2'd0, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign cur_desc_w = r_q.cur;
endmodule

// File: rtl/desc_dma_chk.sv
module desc_dma_chk
    import desc_dma_pkg::*;
#(
    parameter int unsigned ALIGN_BITS = SLOT_BITS
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_we,
    input logic [DW-1:0] req_addr,
    input logic [DW-1:0] req_wdata,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_rdata,
    input logic [DW-1:0] cur_desc
);
    logic          pend_q;
    logic [DW-1:0] last_rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            last_rd_q <= '0;
        end else begin
            if (req_valid && req_ready && !req_we) pend_q <= 1'b1;
            else if (rsp_valid)                    pend_q <= 1'b0;
            if (rsp_valid) last_rd_q <= rsp_rdata;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    p_slot_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cur_desc[ALIGN_BITS-1:0] == '0));

    p_wdata_from_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we) |-> (req_wdata == last_rd_q));

    p_done_means_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_clears_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(start));

    p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_addr) && $stable(req_we) && $stable(req_wdata)));

    p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !req_valid);
endmodule

bind desc_dma desc_dma_chk #(.ALIGN_BITS(ALIGN_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .cur_desc  (cur_desc_w)
);

// File: tb/desc_dma_bench.sv
module desc_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] start_addr;
    logic        busy, done;
    logic        req_valid, req_ready, req_we;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_rdata = '0;

    always #4 clk = ~clk;

    desc_dma u_desc_dma (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .busy       (busy),
        .done       (done),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    // Memory model: 4 KB, one-cycle read latency, optional random back-pressure
    logic [31:0] mem [0:1023];
    logic        stall_mode = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic        log_clr = 1'b0;
    int          rd_n = 0, wr_n = 0, hold_err = 0;
    logic [31:0] rd_log [0:255];
    logic        held = 1'b0;
    logic [31:0] held_addr = '0;
    logic        held_we = 1'b0;

    assign req_ready = !stall_mode || lfsr[0];

    always @(posedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rsp_valid <= 1'b0;
        if (log_clr) begin
            rd_n <= 0;
            wr_n <= 0;
        end else if (req_valid && req_ready) begin
            if (req_we) begin
                mem[req_addr[11:2]] <= req_wdata;
                wr_n <= wr_n + 1;
            end else begin
                rsp_valid <= 1'b1;
                rsp_rdata <= mem[req_addr[11:2]];
                if (rd_n < 256) rd_log[rd_n] <= req_addr;
                rd_n <= rd_n + 1;
            end
        end
        if (held && !(req_valid && req_addr == held_addr && req_we == held_we))
            hold_err <= hold_err + 1;
        held      <= req_valid && !req_ready;
        held_addr <= req_addr;
        held_we   <= req_we;
    end

    int n_chk = 0, n_err = 0;

    task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(logic [31:0] a, logic [31:0] s, logic [31:0] d,
                            logic [31:0] l, logic [31:0] c);
        mem[a[11:2]]     <= s;
        mem[a[11:2] + 1] <= d;
        mem[a[11:2] + 2] <= l;
        mem[a[11:2] + 3] <= c;
    endtask

    task automatic launch(logic [31:0] a, logic stall);
        @(negedge clk);
        stall_mode = stall;
        log_clr    = 1'b1;
        start_addr = a;
        start      = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        start   = 1'b0;
    endtask

    task automatic wait_done();
        int i;
        for (i = 0; i < 5000 && !done; i++) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R7 watchdog: actual done=0 expected done=1");
        end
    endtask

    // {source, destination, byte count}; each run uses one end-of-chain descriptor at 0x100
    localparam logic [95:0] VEC [0:4] = '{
        {32'h0000_0400, 32'h0000_0800, 32'd16},
        {32'h0000_0500, 32'h0000_0900, 32'd4},
        {32'h0000_0600, 32'h0000_0A00, 32'd38},
        {32'h0000_0700, 32'h0000_0B00, 32'd0},
        {32'h0000_0740, 32'h0000_0B40, 32'd3}
    };

    initial begin
        start      = 1'b0;
        start_addr = '0;
        rst_n      = 1'b0;
        for (int k = 0; k < 1024; k++) mem[k] <= 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1", "busy in reset", {31'b0, busy}, 32'd0);
        check_eq("R1", "done in reset", {31'b0, done}, 32'd0);
        check_eq("R1", "req_valid in reset", {31'b0, req_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R1", "req_valid idle", {31'b0, req_valid}, 32'd0);

        // Vector table: single descriptor chains
        for (int i = 0; i < 5; i++) begin
            logic [31:0] s, d, c;
            int          words;
            s = VEC[i][95:64];
            d = VEC[i][63:32];
            c = VEC[i][31:0];
            words = int'(c >> 2);
            for (int k = 0; k <= words; k++) begin
                mem[s[11:2] + k] <= 32'hA000_0000 | (i << 8) | k;
                mem[d[11:2] + k] <= 32'h5E00_0000 | k;
            end
            put_desc(32'h100, s, d, 32'h0000_0001, c);
            launch(32'h100, i[0]);
            wait_done();
            @(negedge clk);
            check_eq("R7", "done after chain", {31'b0, done}, 32'd1);
            check_eq("R7", "busy after chain", {31'b0, busy}, 32'd0);
            check_eq("R4", "write count", wr_n, words);
            check_eq("R5", "read count", rd_n, 4 + words);
            for (int k = 0; k < 4; k++)
                check_eq("R3", "fetch address", rd_log[k], 32'h100 + 4 * k);
            for (int k = 0; k < words; k++) begin
                check_eq("R4", "source read address", rd_log[4 + k], s + 4 * k);
                check_eq("R4", "copied word", mem[d[11:2] + k], 32'hA000_0000 | (i << 8) | k);
            end
            check_eq("R4", "guard past segment", mem[d[11:2] + words], 32'h5E00_0000 | words);
        end

        // Three-descriptor chain: unaligned start, link bits 4:1 set, zero-count middle
        for (int k = 0; k < 2; k++) begin
            mem[12'hC00 / 4 + k] <= 32'hC0DE_0000 | k;
            mem[12'hC80 / 4 + k] <= 32'hC0DE_0080 | k;
            mem[12'hD00 / 4 + k] <= 32'h0;
            mem[12'hD80 / 4 + k] <= 32'h0;
        end
        mem[12'hD40 / 4] <= 32'h6A6A_6A6A;
        put_desc(32'h040, 32'hC00, 32'hD00, 32'h0000_009E, 32'd8);
        put_desc(32'h080, 32'hC40, 32'hD40, 32'h0000_00C0, 32'd0);
        put_desc(32'h0C0, 32'hC80, 32'hD80, 32'h0000_003F, 32'd8);
        launch(32'h05C, 1'b0);
        check_eq("R7", "done cleared by start", {31'b0, done}, 32'd0);
        wait_done();
        @(negedge clk);
        check_eq("R2", "first fetch masked", rd_log[0], 32'h040);
        check_eq("R6", "link bits 4:1 ignored", rd_log[6], 32'h080);
        check_eq("R6", "third descriptor fetch", rd_log[10], 32'h0C0);
        check_eq("R7", "chain read count", rd_n, 16);
        check_eq("R7", "chain write count", wr_n, 4);
        check_eq("R4", "first segment word", mem[12'hD04 / 4], 32'hC0DE_0001);
        check_eq("R7", "third segment word", mem[12'hD84 / 4], 32'hC0DE_0081);
        check_eq("R5", "zero count guard", mem[12'hD40 / 4], 32'h6A6A_6A6A);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 16; k++)
                if (rd_log[k] < 32'h100 && rd_log[k][4]) bad++;
            check_eq("R2", "slot upper half reads", bad, 0);
        end
        repeat (5) @(negedge clk);
        check_eq("R7", "done sticky", {31'b0, done}, 32'd1);

        // Start while busy is ignored
        for (int k = 0; k < 8; k++) mem[12'h400 / 4 + k] <= 32'hB000_0000 | k;
        mem[12'hE00 / 4] <= 32'h5E5E_5E5E;
        put_desc(32'h100, 32'h400, 32'h800, 32'h0000_0001, 32'd32);
        put_desc(32'h140, 32'h500, 32'hE00, 32'h0000_0001, 32'd4);
        launch(32'h100, 1'b1);
        repeat (6) @(negedge clk);
        start_addr = 32'h140;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);
        check_eq("R8", "second chain untouched", mem[12'hE00 / 4], 32'h5E5E_5E5E);
        check_eq("R8", "write count", wr_n, 8);
        check_eq("R8", "read count", rd_n, 12);
        check_eq("R9", "last word under stall", mem[12'h81C / 4], 32'hB000_0007);
        check_eq("R9", "held request changed", hold_err, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule